// File: doc/BRIEF.md
# Nine-bit UART receiver

This block receives asynchronous serial characters on a single input line and presents them through a small register file. A baud generator divides the module clock down to a tick at sixteen times the bit rate. The receive engine uses that tick to find the start bit and to take three samples around the centre of each bit. It shifts either eight or nine data positions into an internal register. Only when the stop bit has been sampled does the character move into the readable buffer.

The ninth data position has its own register bit. In nine-bit mode it holds the ninth received bit. In eight-bit mode it repeats bit 7 of the buffer. When parity is enabled, the last data position of the frame carries the parity bit. A receive-full flag, four sticky error flags (overrun, noise, framing, parity) and two registered interrupt lines let the host either poll the block or run it from interrupts.

The host accesses the register file with one-cycle write and read strobes and a 3-bit address. Read data appears on `rdata` one clock after the read strobe.

Top module: `uart9_rx`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low. The addresses are: 0 line control, 1 interrupt enables, 2 status, 3 data buffer, 4 ninth bit, 5 baud.
- R2: A frame is one low start bit, the data positions LSB first, and one high stop bit. With line-control bit 0 clear (eight-bit mode), the eight received bits appear at address 3, address 4 bit 0 equals received bit 7, and status bit 0 (full) is set.
- R3: With line-control bit 0 set (nine-bit mode), nine data positions are received: bits 0..7 go to address 3 and bit 8 goes to address 4 bit 0.
- R4: The sample tick period is 2^P * (D+1) module clocks, where P is baud register bits 4:3 and D is baud register bits 2:0. One bit lasts sixteen ticks.
- R5: Each bit is decided by a majority vote of three consecutive samples at the centre of the bit. If the three samples disagree, status bit 2 (noise) is set and the voted value is still stored.
- R6: A stop bit that votes low sets status bit 3 (framing) and still delivers the character.
- R7: Line-control bit 1 enables parity and line-control bit 2 selects odd parity (clear means even). The parity bit occupies the last data position. When the ones count over all data positions does not match the selected parity, status bit 4 is set. With parity disabled, that flag never sets.
- R8: A character that completes while the full flag is set sets status bit 1 (overrun) and leaves the buffer and the ninth bit unchanged.
- R9: Reading the status register and then reading the data buffer clears the full flag and all error flags. Reading the data buffer without a preceding status read clears nothing.
- R10: `irq_rx` is high while the full flag and interrupt-enable bit 0 are both set.
- R11: `irq_err` is high while any error flag is set together with its enable. The enables are bit 1 for overrun, bit 2 for noise, bit 3 for framing and bit 4 for parity.
- R12: A low pulse on an idle line that votes high at the start-bit centre is discarded without setting any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid one clock after `rd_en` |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The bench sweeps every eight-bit value and a dense stride of nine-bit values, so any slip in bit order, in the mode select or in the handling of the ninth bit corrupts specific codes. It also exercises both parity senses in both lengths with correct and inverted parity bits; a design that counts the wrong positions or inverts the sense flags good frames. A single-clock glitch inside the sample window must raise noise without corrupting data, while a short low pulse on an idle line must leave no trace; a wrong vote or a start check that is never aborted would show up in these two cases. Overrun must keep the first character, and a data read without a preceding status read must not clear the flags. Several baud settings check the divider formula: a wrong divider receives garbage at those rates.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int OSR    = 16;
  localparam int CNT_W  = $clog2(OSR);
  localparam int DATA_W = 9;
  localparam int IDX_W  = $clog2(DATA_W + 1);

  localparam logic [2:0] A_LINE  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_DATA  = 3'd3;
  localparam logic [2:0] A_NINTH = 3'd4;
  localparam logic [2:0] A_BAUD  = 3'd5;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              nine;
    logic              noise;
    logic              frame;
    logic              par_err;
  } rx_char_t;
endpackage

// File: rtl/uart9_sync.sv
module uart9_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{INIT}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_MAX = (1 << PRE_W) - 1;
  localparam int PER_W   = PRE_MAX + DIV_W + 1;

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] cnt_q;

  always_comb begin
    period = ({{(PER_W-DIV_W){1'b0}}, div} + PER_W'(1)) << pre;
  end

  // >= instead of == so a lowered period cannot strand the counter
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= period - PER_W'(1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart9_vote.sv
module uart9_vote (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic maj,
  output logic split
);
  always_comb begin
    maj   = (a & b) | (a & c) | (b & c);
    split = !((a == b) && (b == c));
  end
endmodule

// File: rtl/uart9_rxfsm.sv
module uart9_rxfsm
  import uart9_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rxs,
  input  logic     nine_mode,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     done,
  output rx_char_t result
);
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              s_a_q, s_b_q;
  logic              noise_q;
  logic              nine_q, pen_q, podd_q;
  logic              vote, split;
  logic [IDX_W-1:0]  last_idx;
  logic              par_bad;

  uart9_vote u_vote (
    .a    (s_a_q),
    .b    (s_b_q),
    .c    (rxs),
    .maj  (vote),
    .split(split)
  );

  always_comb begin
    last_idx = nine_q ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    // unused top position is cleared at start, so the full XOR is safe
    par_bad  = pen_q && ((^shreg_q) != podd_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      noise_q <= 1'b0;
      nine_q  <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state_q == RX_IDLE) begin
          if (!rxs) begin
            state_q <= RX_START;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            noise_q <= 1'b0;
            nine_q  <= nine_mode;
            pen_q   <= par_en;
            podd_q  <= par_odd;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == SMP_A) s_a_q <= rxs;
          if (cnt_q == SMP_B) s_b_q <= rxs;
          if (cnt_q == SMP_C) begin
            case (state_q)
              RX_START: begin
                if (vote) state_q <= RX_IDLE;
                else      noise_q <= noise_q | split;
              end
              RX_DATA: begin
                shreg_q[idx_q] <= vote;
                noise_q        <= noise_q | split;
              end
              RX_STOP: begin
                done           <= 1'b1;
                result.data    <= shreg_q;
                result.nine    <= nine_q;
                result.noise   <= noise_q | split;
                result.frame   <= !vote;
                result.par_err <= par_bad;
                state_q        <= RX_IDLE;
              end
              default: state_q <= RX_IDLE;
            endcase
          end
          if (cnt_q == LAST) begin
            if (state_q == RX_START) begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end else if (state_q == RX_DATA) begin
              if (idx_q == last_idx) state_q <= RX_STOP;
              else                   idx_q   <= idx_q + IDX_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int PRE_W       = 2,
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_rx,
  output logic       irq_err
);
  localparam int BAUD_W = PRE_W + DIV_W;

  logic [2:0]        line_q;
  logic [4:0]        ien_q;
  logic [BAUD_W-1:0] baud_q;
  logic [7:0]        buf_q;
  logic              ninth_q;
  logic              full_q, ovr_q, nf_q, fe_q, pe_q;
  logic              armed_q;
  logic              rxs, tick, rx_done;
  rx_char_t          rx_char;
  logic              clr_evt;
  logic [7:0]        stat_w;

  uart9_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxs)
  );

  uart9_baud #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_baud (
    .clk (clk),
    .rst (rst),
    .pre (baud_q[BAUD_W-1:DIV_W]),
    .div (baud_q[DIV_W-1:0]),
    .tick(tick)
  );

  uart9_rxfsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rxs      (rxs),
    .nine_mode(line_q[0]),
    .par_en   (line_q[1]),
    .par_odd  (line_q[2]),
    .done     (rx_done),
    .result   (rx_char)
  );

  always_comb begin
    clr_evt = rd_en && (addr == A_DATA) && armed_q;
    stat_w  = {3'b000, pe_q, fe_q, nf_q, ovr_q, full_q};
  end

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      ien_q  <= '0;
      baud_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_LINE:  line_q <= wdata[2:0];
        A_IEN:   ien_q  <= wdata[4:0];
        A_BAUD:  baud_q <= wdata[BAUD_W-1:0];
        default: ;
      endcase
    end
  end

  // buffer and flags: the clear sequence applies first, a new character wins
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      ninth_q <= 1'b0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (rd_en && addr == A_STAT) armed_q <= 1'b1;
      if (clr_evt) begin
        full_q  <= 1'b0;
        ovr_q   <= 1'b0;
        nf_q    <= 1'b0;
        fe_q    <= 1'b0;
        pe_q    <= 1'b0;
        armed_q <= 1'b0;
      end
      if (rx_done) begin
        armed_q <= 1'b0;
        if (full_q) begin
          ovr_q <= 1'b1;
        end else begin
          buf_q   <= rx_char.data[7:0];
          ninth_q <= rx_char.nine ? rx_char.data[8] : rx_char.data[7];
          full_q  <= 1'b1;
          if (rx_char.noise)   nf_q <= 1'b1;
          if (rx_char.frame)   fe_q <= 1'b1;
          if (rx_char.par_err) pe_q <= 1'b1;
        end
      end
    end
  end

  // registered read port and interrupt lines
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_rx  <= full_q & ien_q[0];
      irq_err <= |(ien_q[4:1] & {pe_q, fe_q, nf_q, ovr_q});
      if (rd_en) begin
        case (addr)
          A_LINE:  rdata <= {5'b0, line_q};
          A_IEN:   rdata <= {3'b0, ien_q};
          A_STAT:  rdata <= stat_w;
          A_DATA:  rdata <= buf_q;
          A_NINTH: rdata <= {7'b0, ninth_q};
          A_BAUD:  rdata <= 8'(baud_q);
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart9_rx_chk.sv
module uart9_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       full,
  input logic [7:0] buf_v,
  input logic       ovr,
  input logic       nf,
  input logic       done,
  input logic [4:0] ien,
  input logic       irq_rx,
  input logic       irq_err
);
  AST_BUF_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(buf_v)); // R8
  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(full)); // R8
  AST_FULL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(done)); // R2
  AST_NOISE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(nf) |-> $past(done)); // R5
  AST_IRQ_RX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (full && ien[0]) |=> irq_rx); // R10
  AST_IRQ_ERR_MUTED: assert property (@(posedge clk) disable iff (rst)
    (ien[4:1] == 4'b0000) |=> !irq_err); // R11
endmodule

bind uart9_rx uart9_rx_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .full   (full_q),
  .buf_v  (buf_q),
  .ovr    (ovr_q),
  .nf     (nf_q),
  .done   (rx_done),
  .ien    (ien_q),
  .irq_rx (irq_rx),
  .irq_err(irq_err)
);

// File: tb/tb_uart9_rx.sv
`timescale 1ns/1ps
module tb_uart9_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_rx, irq_err;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart9_rx dut (
    .clk(clk), .rst(rst), .rxd(rxd), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // bit_clk = 16 * tick period; glitch only used with bit_clk 16
  task automatic send(input logic [8:0] v, input int nb, input int bit_clk,
                      input int glitch, input logic stop_v);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bit_clk) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = v[i];
      if (glitch == i) begin
        repeat (10) @(negedge clk);
        rxd = ~v[i];
        @(negedge clk);
        rxd = v[i];
        repeat (bit_clk - 11) @(negedge clk);
      end else begin
        repeat (bit_clk) @(negedge clk);
      end
    end
    rxd = stop_v;
    repeat (bit_clk) @(negedge clk);
    rxd = 1'b1;
    repeat (bit_clk) @(negedge clk);
  endtask

  task automatic take(output logic [7:0] st, output logic [7:0] d, output logic [7:0] n);
    rd(3'd2, st);
    rd(3'd3, d);
    rd(3'd4, n);
  endtask

  logic [7:0] st, d, n;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset reg", d, 0);
    end
    chk("R1 irq_rx reset", irq_rx, 0);
    chk("R1 irq_err reset", irq_err, 0);

    // R2 full eight-bit sweep, default baud (tick every clock)
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 8, 16, -1, 1'b1);
      take(st, d, n);
      chk("R2 status full", st, 1);
      chk("R2 data", d, v);
      chk("R2 ninth copy", n, (v >> 7) & 1);
      rd(3'd2, st);
      chk("R9 cleared", st, 0);
    end
    chk("R10 irq_rx off without enable", irq_rx, 0);

    // R3 nine-bit sweep
    wr(3'd0, 8'h01);
    for (int v = 0; v < 512; v += 3) begin
      send(9'(v), 9, 16, -1, 1'b1);
      take(st, d, n);
      chk("R3 status", st, 1);
      chk("R3 data", d, v & 8'hff);
      chk("R3 ninth bit", n, (v >> 8) & 1);
    end

    // R7 parity, both lengths and senses
    for (int mode = 0; mode < 4; mode++) begin
      int nb;
      logic odd;
      nb  = (mode[0]) ? 9 : 8;
      odd = mode[1];
      wr(3'd0, {5'b0, odd, 1'b1, mode[0]});
      for (int v = 0; v < 128; v += 11) begin
        logic [8:0] fr;
        logic p;
        fr = (nb == 9) ? 9'(v * 2 + 1) : 9'(v);
        fr[nb-1] = 1'b0;
        p = (^fr) ^ odd;
        fr[nb-1] = p;
        send(fr, nb, 16, -1, 1'b1);
        take(st, d, n);
        chk("R7 good parity", st, 1);
        chk("R7 data", d, fr[7:0]);
        fr[nb-1] = ~p;
        send(fr, nb, 16, -1, 1'b1);
        take(st, d, n);
        chk("R7 bad parity", st, 8'h11);
      end
    end
    wr(3'd0, 8'h00);

    // R5 noise: one-clock glitch inside the three-sample window
    send(9'h0a5, 8, 16, 3, 1'b1);
    take(st, d, n);
    chk("R5 noise flag", st, 8'h05);
    chk("R5 voted data", d, 8'ha5);
    send(9'h05a, 8, 16, 0, 1'b1);
    take(st, d, n);
    chk("R5 noise bit0", st, 8'h05);
    chk("R5 voted data bit0", d, 8'h5a);

    // R6 framing
    send(9'h03c, 8, 16, -1, 1'b0);
    take(st, d, n);
    chk("R6 framing flag", st, 8'h09);
    chk("R6 data kept", d, 8'h3c);

    // R8 overrun keeps the first character
    send(9'h111, 9, 16, -1, 1'b1);
    send(9'h022, 8, 16, -1, 1'b1);
    take(st, d, n);
    chk("R8 overrun status", st, 8'h03);
    chk("R8 old data", d, 8'h11);
    chk("R8 old ninth", n, 0);
    rd(3'd2, st);
    chk("R9 overrun cleared", st, 0);

    // R9 data read alone clears nothing
    send(9'h055, 8, 16, -1, 1'b1);
    rd(3'd3, d);
    chk("R9 data", d, 8'h55);
    rd(3'd2, st);
    chk("R9 still full", st, 1);
    rd(3'd3, d);
    rd(3'd2, st);
    chk("R9 cleared after sequence", st, 0);

    // R10 receive interrupt
    wr(3'd1, 8'h01);
    send(9'h077, 8, 16, -1, 1'b1);
    chk("R10 irq_rx set", irq_rx, 1);
    chk("R11 irq_err quiet", irq_err, 0);
    take(st, d, n);
    repeat (2) @(negedge clk);
    chk("R10 irq_rx cleared", irq_rx, 0);

    // R11 error interrupt gating
    wr(3'd1, 8'h08);
    send(9'h081, 8, 16, -1, 1'b0);
    chk("R11 framing irq", irq_err, 1);
    chk("R10 irq_rx masked", irq_rx, 0);
    take(st, d, n);
    repeat (2) @(negedge clk);
    chk("R11 irq_err cleared", irq_err, 0);
    wr(3'd1, 8'h04);
    send(9'h081, 8, 16, -1, 1'b0);
    chk("R11 framing masked", irq_err, 0);
    take(st, d, n);
    chk("R11 framing flag still set", st, 8'h09);
    wr(3'd1, 8'h02);
    send(9'h001, 8, 16, -1, 1'b1);
    chk("R11 no overrun yet", irq_err, 0);
    send(9'h002, 8, 16, -1, 1'b1);
    chk("R11 overrun irq", irq_err, 1);
    take(st, d, n);
    wr(3'd1, 8'h00);

    // R12 short low pulse is discarded
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    rd(3'd2, st);
    chk("R12 no flags after glitch", st, 0);
    send(9'h0e7, 8, 16, -1, 1'b1);
    take(st, d, n);
    chk("R12 next char status", st, 1);
    chk("R12 next char data", d, 8'he7);

    // R4 baud settings: period = 2^P * (D+1)
    for (int c = 0; c < 5; c++) begin
      int p, dv, per;
      logic [7:0] v;
      p  = (c == 0) ? 1 : (c == 1) ? 0 : (c == 2) ? 2 : (c == 3) ? 0 : 1;
      dv = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 0 : (c == 3) ? 6 : 3;
      per = (1 << p) * (dv + 1);
      v = 8'(8'h3b + c * 8'h47);
      wr(3'd5, 8'((p << 3) | dv));
      rd(3'd5, d);
      chk("R4 baud readback", d, (p << 3) | dv);
      send({1'b0, v}, 8, 16 * per, -1, 1'b1);
      take(st, d, n);
      chk("R4 status at rate", st, 1);
      chk("R4 data at rate", d, v);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule